// File: doc/BRIEF.md
# Serial-Out Shifter with Zero Padding

This block takes a four-bit word in parallel and sends it out one bit per clock on a single wire, least significant bit first. A two-state controller decides what the wire carries on each cycle: waiting, or shifting a captured word. Whenever no data bit is being sent, the wire is held low. This includes the idle time after a word has finished and any cycle where the load strobe is raised during a shift.

A load strobe seen on a rising clock edge while the controller waits captures the word and starts a shift. Each following clock with the strobe low sends the next bit. A strobe raised in the middle of a shift pauses it for that cycle. It drives the wire low and does not replace the captured word. After the fourth bit has gone out, the controller waits again and the wire stays low until the next load. The serial output is registered, so a bit appears on the wire one clock after the edge that selects it.

Top module: `piso_zero_pad`

## Requirements
- R1: While reset is asserted, and right after it is released, the controller is waiting, the bit position is 0 and `serOut` is 0.
- R2: In any cycle that starts with the controller waiting, the next edge drives `serOut` to 0, whatever the value of `loadReq`.
- R3: A waiting controller that sees `loadReq` high on a rising edge captures `parIn` as it is at that edge and starts shifting. Later changes to `parIn` have no effect on the word being sent.
- R4: While shifting with `loadReq` low, each edge drives `serOut` with one captured bit. The bits go out in index order 0, 1, 2, 3, so bit 0 (the LSB of `parIn`) comes first.
- R5: The edge that sends bit 3 returns the controller to waiting. From the next edge on, `serOut` stays 0 until a new load.
- R6: While shifting, an edge with `loadReq` high drives `serOut` to 0. It does not recapture `parIn` and does not advance the bit position, so the next edge with `loadReq` low sends the bit that was due.
- R7: The bit position wraps from 3 back to 0 on the final bit. A word loaded straight after another one therefore starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| loadReq | input | 1 | Load strobe: captures a word when waiting, pauses the shift when shifting |
| parIn | input | WORD_BITS (4) | Parallel word to be sent |
| serOut | output | 1 | Serial data, LSB first, 0 when no bit is being sent |

## Verification
The hardest case to reach is a load strobe that lands during a shift. It has to arrive after one to three bits have already left, and its effect shows only in which bit follows the pause and in whether the new `parIn` ever appears. Directed sequences raise the strobe at a chosen bit position, change `parIn` during the pause, and then check the rest of the stream. A second word loaded on the cycle right after the final bit confirms the restart at bit 0. Random strobes at about one in four cycles then cover pauses at every position.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic {
    ST_WAIT  = 1'b0,
    ST_SHIFT = 1'b1
  } piso_state_t;

  typedef struct packed {
    logic capture;
    logic emit;
  } piso_strobe_t;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadReq,
  input  logic         atLast,
  output piso_strobe_t strobe,
  output piso_state_t  ctrlState
);

  piso_state_t nextState;

  always_comb begin
    nextState      = ctrlState;
    strobe.capture = 1'b0;
    strobe.emit    = 1'b0;
    unique case (ctrlState)
      ST_WAIT: begin
        if (loadReq) begin
          strobe.capture = 1'b1;
          nextState      = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (!loadReq) begin
          strobe.emit = 1'b1;
          if (atLast) nextState = ST_WAIT;
        end
      end
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) ctrlState <= ST_WAIT;
    else     ctrlState <= nextState;
  end

endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WORD_BITS = 4,
  localparam int CNT_W    = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  piso_strobe_t         strobe,
  input  logic [WORD_BITS-1:0] parIn,
  output logic                 atLast,
  output logic [CNT_W-1:0]     bitPos,
  output logic [WORD_BITS-1:0] wordHeld,
  output logic                 serOut
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0] posNext;

  assign atLast  = (bitPos == LAST_POS);
  assign posNext = atLast ? '0 : bitPos + CNT_W'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wordHeld <= '0;
    end else if (strobe.capture) begin
      wordHeld <= parIn;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bitPos <= '0;
      serOut <= 1'b0;
    end else if (strobe.emit) begin
      bitPos <= posNext;
      serOut <= wordHeld[bitPos];
    end else begin
      serOut <= 1'b0;
    end
  end

endmodule

// File: rtl/piso_zero_pad.sv
module piso_zero_pad
  import piso_pkg::*;
#(
  parameter int WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loadReq,
  input  logic [WORD_BITS-1:0] parIn,
  output logic                 serOut
);

  localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  piso_strobe_t           strobe;
  piso_state_t            ctrlState;
  logic                   atLast;
  logic [CNT_W-1:0]       bitPos;
  logic [WORD_BITS-1:0]   wordHeld;

  piso_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .loadReq   (loadReq),
    .atLast    (atLast),
    .strobe    (strobe),
    .ctrlState (ctrlState)
  );

  piso_datapath #(.WORD_BITS(WORD_BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .parIn    (parIn),
    .atLast   (atLast),
    .bitPos   (bitPos),
    .wordHeld (wordHeld),
    .serOut   (serOut)
  );

endmodule

// File: rtl/piso_zero_pad_chk.sv
module piso_zero_pad_chk
  import piso_pkg::*;
#(
  parameter int WORD_BITS = 4,
  localparam int CNT_W    = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 loadReq,
  input logic [WORD_BITS-1:0] parIn,
  input logic                 serOut,
  input piso_state_t          ctrlState,
  input logic [CNT_W-1:0]     bitPos,
  input logic [WORD_BITS-1:0] wordHeld
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_BITS - 1);

  always_comb begin
    if (rst) begin
      AST_RESET_QUIET: assert (serOut == 1'b0 && bitPos == '0 && ctrlState == ST_WAIT); // R1
    end
  end

  AST_WAIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_WAIT) |=> (serOut == 1'b0)); // R2

  AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_WAIT && loadReq) |=> (ctrlState == ST_SHIFT && wordHeld == $past(parIn))); // R3

  AST_SEND_BIT: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_SHIFT && !loadReq) |=> (serOut == $past(wordHeld[bitPos]))); // R4

  AST_FINAL_RETURN: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_SHIFT && !loadReq && bitPos == LAST_POS) |=> (ctrlState == ST_WAIT)); // R5

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_SHIFT && loadReq) |=> (serOut == 1'b0 && $stable(bitPos) && $stable(wordHeld))); // R6

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_SHIFT && !loadReq && bitPos == LAST_POS) |=> (bitPos == '0)); // R7

endmodule

bind piso_zero_pad piso_zero_pad_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loadReq   (loadReq),
  .parIn     (parIn),
  .serOut    (serOut),
  .ctrlState (ctrlState),
  .bitPos    (bitPos),
  .wordHeld  (wordHeld)
);

// File: tb/piso_zero_pad_bench.sv
`timescale 1ns/1ps
module piso_zero_pad_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadReq = 1'b0;
  logic [3:0] parIn = 4'h0;
  logic       serOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // requirement-level model of the expected wire
  bit       mShift = 1'b0;
  int       mPos   = 0;
  bit [3:0] mWord  = 4'h0;
  bit       mOut   = 1'b0;

  always #2 clk = ~clk;

  piso_zero_pad u_piso_zero_pad (
    .clk     (clk),
    .rst     (rst),
    .loadReq (loadReq),
    .parIn   (parIn),
    .serOut  (serOut)
  );

  function automatic string pickTag(bit inShift, bit ld, int pos);
    if (!inShift) return ld ? "R3" : "R2";
    if (ld)       return "R6";
    if (pos == 3) return "R5";
    return "R4";
  endfunction

  task automatic check(bit expected, string tag);
    nChecks++;
    if (serOut !== expected) begin
      nFails++;
      $display("FAIL %s: serOut actual=%b expected=%b at %0t", tag, serOut, expected, $time);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, sample 1 ns later
  task automatic step(bit ld, bit [3:0] d, string forceTag = "");
    string tag;
    @(negedge clk);
    loadReq = ld;
    parIn   = d;
    tag = (forceTag != "") ? forceTag : pickTag(mShift, ld, mPos);
    if (!mShift) begin
      mOut = 1'b0;
      if (ld) begin
        mWord  = d;
        mShift = 1'b1;
      end
    end else if (ld) begin
      mOut = 1'b0;
    end else begin
      mOut = mWord[mPos];
      if (mPos == 3) begin
        mPos   = 0;
        mShift = 1'b0;
      end else begin
        mPos++;
      end
    end
    @(posedge clk);
    #1;
    check(mOut, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
    step(0, 4'hF, "R1");
    step(0, 4'hF, "R2");

    // R3 R4 R5: one word, LSB first, then zero padding
    step(1, 4'b1011);
    for (int i = 0; i < 4; i++) step(0, 4'h0);
    for (int i = 0; i < 3; i++) step(0, 4'hF, "R5");

    // R7: back-to-back words, second starts at bit 0
    step(1, 4'b0110);
    for (int i = 0; i < 4; i++) step(0, 4'h0);
    step(1, 4'b1001, "R7");
    for (int i = 0; i < 4; i++) step(0, 4'h0, "R7");
    step(0, 4'h0, "R5");

    // R6: pause mid-shift with new data presented; no reload, position held
    step(1, 4'b1101);
    step(0, 4'h0);
    step(1, 4'b0010, "R6");
    step(1, 4'b0010, "R6");
    for (int i = 0; i < 3; i++) step(0, 4'b0010, "R6");
    step(0, 4'h0);

    // R3: load held across several cycles, captured value is the first edge's
    step(1, 4'b0001);
    step(1, 4'b1110, "R3");
    step(1, 4'b1110, "R3");
    for (int i = 0; i < 4; i++) step(0, 4'b1110, "R3");
    step(0, 4'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) == 0, 4'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule